// File: doc/BRIEF.md
# Processor Sleep-State Clock Controller

This block tracks the low-power state of a processor core and turns that state into clock-enable and request-gating signals. It has three states: Normal, Stop Grant and Sleep. Two active-low request lines move it between them, one asking for a clock stop and one asking for sleep. A third active-low line is the processor reset. The controller drives separate clock enables for the bus unit, the interrupt-controller (APIC) unit and the core, plus an enable that keeps the PLL running. It also sits in the path of incoming snoop and interrupt requests and blocks them while the core is asleep.

The clock-stop and sleep lines are asynchronous. Each passes through a multi-stage synchroniser before the state register sees it. The reset line asserts asynchronously and releases through its own synchroniser. Sleep is reached only by way of Stop Grant. Leaving Sleep always lands in Stop Grant first.

Top module: `nap_clock_ctrl`

## Requirements
- R1: While `cpu_rst_n` is low, the state output is 2'b00 (Normal) at once, with no clock edge needed. All four enables are high and both acknowledge outputs are low. The controller stays in Normal after `cpu_rst_n` returns high.
- R2: With `stpclk_n` low in Normal (2'b00), the state output is 2'b01 (Stop Grant) after the third rising clock edge and not after the second. In Stop Grant, `core_clk_en` is low and `bus_clk_en`, `apic_clk_en` and `pll_en` are high.
- R3: With `stpclk_n` high and `slp_n` high in Stop Grant, the controller returns to Normal (2'b00), with all four enables high.
- R4: `slp_n` low while in Normal has no effect: the state stays 2'b00 and all enables stay high.
- R5: `slp_n` low while in Stop Grant moves the controller to Sleep (2'b10). In Sleep, `bus_clk_en`, `apic_clk_en` and `core_clk_en` are low and `pll_en` stays high.
- R6: In Sleep, `snoop_fwd` is low and every bit of `intr_fwd` is low whatever the requests are. `snoop_ack` and `intr_ack` stay low on the following cycle.
- R7: In Sleep, raising `stpclk_n` while `slp_n` stays low has no effect, and snoop or interrupt requests do not change the state.
- R8: Raising `slp_n` in Sleep moves the controller to Stop Grant (2'b01), which turns `bus_clk_en` and `apic_clk_en` back on.
- R9: Outside Sleep, `snoop_fwd` equals `snoop_req` and `intr_fwd` equals `intr_req` in the same cycle. Each acknowledge bit is high exactly one rising edge after the matching request was forwarded.
- R10: When both request lines are released together in Sleep, the controller spends exactly one cycle in Stop Grant and then enters Normal.
- R11: The state output never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| cpu_rst_n | input | 1 | Active-low processor reset; asserts asynchronously, releases through a synchroniser |
| stpclk_n | input | 1 | Active-low clock-stop request, asynchronous |
| slp_n | input | 1 | Active-low sleep request, asynchronous |
| snoop_req | input | 1 | Incoming snoop request |
| intr_req | input | INTR_W | Incoming interrupt request lines |
| state_o | output | 2 | Current state: 00 Normal, 01 Stop Grant, 10 Sleep |
| bus_clk_en | output | 1 | Bus unit clock enable |
| apic_clk_en | output | 1 | Interrupt-controller unit clock enable |
| core_clk_en | output | 1 | Core clock enable |
| pll_en | output | 1 | PLL run enable |
| snoop_fwd | output | 1 | Snoop request passed on to the core |
| intr_fwd | output | INTR_W | Interrupt requests passed on to the core |
| snoop_ack | output | 1 | Acknowledge of a forwarded snoop, one cycle later |
| intr_ack | output | INTR_W | Acknowledge of forwarded interrupts, one cycle later |

## Verification
A change on `stpclk_n` or `slp_n` takes two edges to cross the synchroniser and a third to reach the state register. The bench therefore drives on a falling edge and samples the state and the enables on the falling edge after the third rising edge. In the corner tests it also samples after the second rising edge, to show the state has not moved early. Forwarding is combinational, so it is sampled a short delay after the request changes in the same cycle. Acknowledges are sampled one rising edge later. The reset result is checked a short delay after `cpu_rst_n` falls, without waiting for a clock.

// File: rtl/nap_pkg.sv
`timescale 1ns/1ps
package nap_pkg;

   typedef enum logic [1:0] {
      NAP_NORMAL = 2'b00,
      NAP_GRANT  = 2'b01,
      NAP_SLEEP  = 2'b10
   } nap_state_e;

   typedef struct packed {
      logic bus;
      logic apic;
      logic core;
      logic pll;
   } nap_clk_en_t;

   function automatic nap_clk_en_t nap_enables(input nap_state_e st);
      nap_clk_en_t e;
      e.pll  = 1'b1;
      e.core = (st == NAP_NORMAL);
      e.bus  = (st != NAP_SLEEP);
      e.apic = (st != NAP_SLEEP);
      return e;
   endfunction

endpackage

// File: rtl/nap_rst_sync.sv
`timescale 1ns/1ps
module nap_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("nap_rst_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/nap_sync_bank.sv
`timescale 1ns/1ps
module nap_sync_bank #(
   parameter int        WIDTH   = 2,
   parameter int        STAGES  = 2,
   parameter logic      RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("nap_sync_bank: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("nap_sync_bank: WIDTH must be at least 1");
      end
   endgenerate

   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] flop;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flop <= {STAGES{RST_VAL}};
            else        flop <= {flop[STAGES-2:0], d_async[b]};
         end
         assign q_sync[b] = flop[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/nap_state_fsm.sv
`timescale 1ns/1ps
module nap_state_fsm
   import nap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stop_act,
   input  logic       sleep_act,
   output nap_state_e state
);
   nap_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         NAP_NORMAL: begin
            if (stop_act) nxt = NAP_GRANT;
         end
         NAP_GRANT: begin
            if (sleep_act)      nxt = NAP_SLEEP;
            else if (!stop_act) nxt = NAP_NORMAL;
         end
         NAP_SLEEP: begin
            if (!sleep_act) nxt = NAP_GRANT;
         end
         default: nxt = NAP_NORMAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= NAP_NORMAL;
      else        state <= nxt;
   end
endmodule

// File: rtl/nap_req_gate.sv
`timescale 1ns/1ps
module nap_req_gate #(
   parameter int INTR_W = 4,
   parameter bit ACK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              asleep,
   input  logic              snoop_req,
   input  logic [INTR_W-1:0] intr_req,
   output logic              snoop_fwd,
   output logic [INTR_W-1:0] intr_fwd,
   output logic              snoop_ack,
   output logic [INTR_W-1:0] intr_ack
);
   generate
      if (INTR_W < 1) begin : g_bad_w
         $error("nap_req_gate: INTR_W must be at least 1");
      end
   endgenerate

   assign snoop_fwd = snoop_req & ~asleep;

   genvar i;
   generate
      for (i = 0; i < INTR_W; i++) begin : g_mask
         assign intr_fwd[i] = intr_req[i] & ~asleep;
      end

      if (ACK_EN) begin : g_ack
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               snoop_ack <= 1'b0;
               intr_ack  <= '0;
            end else begin
               snoop_ack <= snoop_fwd;
               intr_ack  <= intr_fwd;
            end
         end
      end else begin : g_no_ack
         assign snoop_ack = 1'b0;
         assign intr_ack  = '0;
      end
   endgenerate
endmodule

// File: rtl/nap_clock_ctrl.sv
`timescale 1ns/1ps
module nap_clock_ctrl
   import nap_pkg::*;
#(
   parameter int INTR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int RST_STAGES  = 2,
   parameter bit ACK_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              cpu_rst_n,
   input  logic              stpclk_n,
   input  logic              slp_n,
   input  logic              snoop_req,
   input  logic [INTR_W-1:0] intr_req,
   output logic [1:0]        state_o,
   output logic              bus_clk_en,
   output logic              apic_clk_en,
   output logic              core_clk_en,
   output logic              pll_en,
   output logic              snoop_fwd,
   output logic [INTR_W-1:0] intr_fwd,
   output logic              snoop_ack,
   output logic [INTR_W-1:0] intr_ack
);
   localparam int NREQ = 2;

   logic            rst_s_n;
   logic [NREQ-1:0] req_raw_n;
   logic [NREQ-1:0] req_s_n;
   nap_state_e      st;
   nap_clk_en_t     en;

   nap_rst_sync #(.STAGES(RST_STAGES)) u_rst (
      .clk    (clk),
      .arst_n (cpu_rst_n),
      .srst_n (rst_s_n)
   );

   assign req_raw_n = {slp_n, stpclk_n};

   nap_sync_bank #(.WIDTH(NREQ), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .d_async (req_raw_n),
      .q_sync  (req_s_n)
   );

   nap_state_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .stop_act  (~req_s_n[0]),
      .sleep_act (~req_s_n[1]),
      .state     (st)
   );

   assign en          = nap_enables(st);
   assign state_o     = st;
   assign bus_clk_en  = en.bus;
   assign apic_clk_en = en.apic;
   assign core_clk_en = en.core;
   assign pll_en      = en.pll;

   nap_req_gate #(.INTR_W(INTR_W), .ACK_EN(ACK_EN)) u_gate (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .asleep    (st == NAP_SLEEP),
      .snoop_req (snoop_req),
      .intr_req  (intr_req),
      .snoop_fwd (snoop_fwd),
      .intr_fwd  (intr_fwd),
      .snoop_ack (snoop_ack),
      .intr_ack  (intr_ack)
   );
endmodule

// File: rtl/nap_clock_ctrl_chk.sv
`timescale 1ns/1ps
module nap_clock_ctrl_chk #(
   parameter int INTR_W = 4
) (
   input logic              clk,
   input logic              cpu_rst_n,
   input logic [1:0]        state_o,
   input logic              bus_clk_en,
   input logic              apic_clk_en,
   input logic              core_clk_en,
   input logic              pll_en,
   input logic              snoop_fwd,
   input logic [INTR_W-1:0] intr_fwd,
   input logic              snoop_ack,
   input logic [INTR_W-1:0] intr_ack
);
   AST_RESET_NORMAL: assert property (@(posedge clk)
      !cpu_rst_n |-> (state_o == 2'b00 && bus_clk_en && apic_clk_en && core_clk_en && pll_en)); // R1

   AST_SLEEP_FROM_GRANT: assert property (@(posedge clk) disable iff (!cpu_rst_n)
      (state_o == 2'b10 && $past(state_o) != 2'b10) |-> $past(state_o) == 2'b01); // R5

   AST_NORMAL_NO_SLEEP: assert property (@(posedge clk) disable iff (!cpu_rst_n)
      $past(state_o) == 2'b00 |-> state_o != 2'b10); // R4

   AST_SLEEP_CLOCKS: assert property (@(posedge clk) disable iff (!cpu_rst_n)
      state_o == 2'b10 |-> (pll_en && !bus_clk_en && !apic_clk_en && !core_clk_en)); // R5

   AST_SLEEP_MASK: assert property (@(posedge clk) disable iff (!cpu_rst_n)
      state_o == 2'b10 |-> (!snoop_fwd && intr_fwd == '0)); // R6

   AST_SLEEP_NO_ACK: assert property (@(posedge clk) disable iff (!cpu_rst_n)
      $past(state_o) == 2'b10 |-> (!snoop_ack && intr_ack == '0)); // R6

   AST_WAKE_TO_GRANT: assert property (@(posedge clk) disable iff (!cpu_rst_n)
      ($past(state_o) == 2'b10 && state_o != 2'b10) |-> state_o == 2'b01); // R8

   AST_CORE_NEEDS_PLL: assert property (@(posedge clk) disable iff (!cpu_rst_n)
      core_clk_en |-> (pll_en && bus_clk_en)); // R2

   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!cpu_rst_n)
      state_o != 2'b11); // R11
endmodule

bind nap_clock_ctrl nap_clock_ctrl_chk #(.INTR_W(INTR_W)) u_chk (
   .clk         (clk),
   .cpu_rst_n   (cpu_rst_n),
   .state_o     (state_o),
   .bus_clk_en  (bus_clk_en),
   .apic_clk_en (apic_clk_en),
   .core_clk_en (core_clk_en),
   .pll_en      (pll_en),
   .snoop_fwd   (snoop_fwd),
   .intr_fwd    (intr_fwd),
   .snoop_ack   (snoop_ack),
   .intr_ack    (intr_ack)
);

// File: tb/sim_nap_clock_ctrl.sv
`timescale 1ns/1ps
module sim_nap_clock_ctrl;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         cpu_rst_n = 1'b0;
   logic         stpclk_n = 1'b1;
   logic         slp_n = 1'b1;
   logic         snoop_req = 1'b0;
   logic [W-1:0] intr_req = '0;
   logic [1:0]   state_o;
   logic         bus_clk_en, apic_clk_en, core_clk_en, pll_en;
   logic         snoop_fwd, snoop_ack;
   logic [W-1:0] intr_fwd, intr_ack;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   nap_clock_ctrl #(.INTR_W(W)) u0 (
      .clk(clk), .cpu_rst_n(cpu_rst_n), .stpclk_n(stpclk_n), .slp_n(slp_n),
      .snoop_req(snoop_req), .intr_req(intr_req), .state_o(state_o),
      .bus_clk_en(bus_clk_en), .apic_clk_en(apic_clk_en),
      .core_clk_en(core_clk_en), .pll_en(pll_en),
      .snoop_fwd(snoop_fwd), .intr_fwd(intr_fwd),
      .snoop_ack(snoop_ack), .intr_ack(intr_ack)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] en_of(input logic [1:0] st);
      case (st)
         2'b00:   return 4'b1111;
         2'b01:   return 4'b1101;
         default: return 4'b0001;
      endcase
   endfunction

   task automatic check_state(input string tag, input logic [1:0] st);
      check({tag, " state"}, state_o, st);
      check({tag, " enables"}, {bus_clk_en, apic_clk_en, core_clk_en, pll_en}, en_of(st));
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   // vector: {stpclk_n, slp_n, snoop_req, intr_req[3:0], exp_state[1:0]}
   localparam int NV = 9;
   localparam logic [8:0] VEC [NV] = '{
      {1'b1, 1'b1, 1'b0, 4'h0, 2'b00},   // R3 idle Normal
      {1'b1, 1'b0, 1'b0, 4'h0, 2'b00},   // R4 sleep request in Normal ignored
      {1'b0, 1'b1, 1'b0, 4'h0, 2'b01},   // R2 stop grant
      {1'b0, 1'b0, 1'b0, 4'h0, 2'b10},   // R5 sleep from grant
      {1'b1, 1'b0, 1'b0, 4'h0, 2'b10},   // R7 stpclk release ignored
      {1'b1, 1'b0, 1'b1, 4'hf, 2'b10},   // R6 R7 requests masked
      {1'b0, 1'b1, 1'b0, 4'h0, 2'b01},   // R8 wake to grant
      {1'b1, 1'b1, 1'b0, 4'h0, 2'b00},   // R3 back to Normal
      {1'b0, 1'b1, 1'b1, 4'h5, 2'b01}    // R9 forwarding in grant
   };

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R1 actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #1;
      check_state("R1 async reset", 2'b00);
      check("R1 ack in reset", {snoop_ack, intr_ack}, '0);
      repeat (3) @(posedge clk);
      @(negedge clk) cpu_rst_n = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check_state("R1 after release", 2'b00);

      for (int i = 0; i < NV; i++) begin
         logic [1:0] es;
         @(negedge clk);
         {stpclk_n, slp_n, snoop_req, intr_req, es} = VEC[i];
         settle();
         check_state($sformatf("R2 R5 vector %0d", i), es);
         check($sformatf("R6 R9 snoop_fwd vector %0d", i), snoop_fwd,
               (es == 2'b10) ? 1'b0 : snoop_req);
         check($sformatf("R6 R9 intr_fwd vector %0d", i), intr_fwd,
               (es == 2'b10) ? 4'h0 : intr_req);
         check($sformatf("R11 legal vector %0d", i), state_o != 2'b11, 1'b1);
      end

      // R9: same-cycle forwarding and one-edge acknowledge in Normal
      snoop_req = 1'b0; intr_req = '0; stpclk_n = 1'b1;
      settle(); @(negedge clk);
      check_state("R3 grant to normal", 2'b00);
      snoop_req = 1'b1; intr_req = 4'h3;
      #1;
      check("R9 snoop_fwd same cycle", snoop_fwd, 1'b1);
      check("R9 intr_fwd same cycle", intr_fwd, 4'h3);
      @(posedge clk); @(negedge clk);
      check("R9 snoop_ack next edge", snoop_ack, 1'b1);
      check("R9 intr_ack next edge", intr_ack, 4'h3);
      snoop_req = 1'b0; intr_req = '0;
      @(posedge clk); @(negedge clk);
      check("R9 ack drops", {snoop_ack, intr_ack}, '0);

      // R6 R7: requests in Sleep
      stpclk_n = 1'b0; settle(); @(negedge clk);
      slp_n = 1'b0; settle(); @(negedge clk);
      check_state("R5 sleep again", 2'b10);
      snoop_req = 1'b1; intr_req = 4'hf;
      #1;
      check("R6 snoop blocked", snoop_fwd, 1'b0);
      check("R6 intr blocked", intr_fwd, 4'h0);
      @(posedge clk); @(negedge clk);
      check("R6 no ack", {snoop_ack, intr_ack}, '0);
      check_state("R7 requests leave state", 2'b10);
      snoop_req = 1'b0; intr_req = '0;

      // R10: both released together; also shows no early move (R2 timing)
      stpclk_n = 1'b1; slp_n = 1'b1;
      repeat (2) @(posedge clk); @(negedge clk);
      check_state("R10 no move after two edges", 2'b10);
      @(posedge clk); @(negedge clk);
      check_state("R10 one cycle in grant", 2'b01);
      @(posedge clk); @(negedge clk);
      check_state("R10 then normal", 2'b00);

      // R2: stop request timing from Normal
      stpclk_n = 1'b0;
      repeat (2) @(posedge clk); @(negedge clk);
      check_state("R2 not after second edge", 2'b00);
      @(posedge clk); @(negedge clk);
      check_state("R2 grant after third edge", 2'b01);

      // R1: reset from Sleep
      slp_n = 1'b0; settle(); @(negedge clk);
      check_state("R5 sleep before reset", 2'b10);
      cpu_rst_n = 1'b0;
      #1;
      check_state("R1 reset from sleep", 2'b00);
      repeat (2) @(posedge clk);
      @(negedge clk) begin stpclk_n = 1'b1; slp_n = 1'b1; cpu_rst_n = 1'b1; end
      repeat (5) @(posedge clk); @(negedge clk);
      check_state("R1 normal after reset", 2'b00);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule